// File: doc/BRIEF.md
# Saturating Event Counter with Snapshot Update

This block counts single-cycle event strobes in a running counter that stops at its top value instead of wrapping. The running count is not visible directly. Software or a monitoring engine raises an update request, and on the rising edge of that request the block copies the running count into a holding register and restarts the counter. The holding register drives an output port, so a reader sees a stable figure for one complete measurement interval.

The update is a short handshake. The controller is a three-state machine. `ST_IDLE` is the state after reset, when no snapshot has been taken and the status flag is low. `ST_SNAP` is the single update cycle: the status flag is low and the non-zero indicator is forced low. `ST_READY` holds after each completed update, with the status flag high. The transitions are `IDLE->SNAP` and `READY->SNAP` on a request rising edge, and `SNAP->READY` unconditionally one cycle later. At the edge that leaves `ST_SNAP`, the holding register takes the count and the counter restarts from the event strobe of that same cycle, so no event is lost. An active-low data-path reset clears the counter, the holding register and the controller.

Top module: `perf_snap_counter`

## Requirements
- R1: While `rst_n` is low, and until the first update after it is released, `snap_q` is 0, `upd_ready` is 0 and `snap_nz` is 0.
- R2: Each clock edge that samples `evt` high adds one to the running count. The count shows in `snap_q` after the next update.
- R3: The running count stops at 2^CNT_W-1 (all ones) and never wraps to zero.
- R4: An update starts only on a rising edge of `upd_req` (sampled 1 after being sampled 0). Holding `upd_req` high starts no further update.
- R5: In the one cycle after the edge that sees the rising request (state `ST_SNAP`), `upd_ready` is 0.
- R6: At the edge that leaves `ST_SNAP`, `snap_q` loads the running count, including an event sampled at the rising-request edge. The running count then restarts.
- R7: `snap_nz` is 1 exactly when `snap_q` is non-zero, except in the `ST_SNAP` cycle, when it is forced to 0 for exactly one clock.
- R8: After an update completes, `upd_ready` is 1 and stays 1 until the next rising edge of `upd_req`.
- R9: An event sampled at the same edge that loads `snap_q` is not lost. The restarted count becomes 1.
- R10: Two updates with no events between them leave `snap_q` at 0. The first update clears the counter and the second loads that zero.
- R11: Asserting `rst_n` low at any time clears both the running count and `snap_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous data-path reset |
| evt | input | 1 | Event strobe, one count per sampled high cycle |
| upd_req | input | 1 | Update request; its rising edge starts an update |
| snap_q | output | CNT_W | Holding register, the last snapshot of the count |
| upd_ready | output | 1 | High once an update has completed; low during an update |
| snap_nz | output | 1 | High when `snap_q` is non-zero; forced low in the update cycle |

## Verification
Two actions can fall into the same clock edge: the counter restart caused by loading the snapshot, and the increment caused by an event strobe. The increment can also coincide with the rising-request edge itself, and with saturation. The bench provokes each case directly by driving `evt` high at the request edge, at the load edge and while the count sits at its top value. It then runs long random mixes of events and requests. A behavioural model that counts with plain integers supplies the expected `snap_q`, `upd_ready` and `snap_nz` after every clock.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SNAP  = 2'd1,
        ST_READY = 2'd2
    } psc_state_e;
endpackage

// File: rtl/psc_rise_det.sv
module psc_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rise_o
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_i;
    end

    assign rise_o = req_i & ~req_q;
endmodule

// File: rtl/psc_sat_counter.sv
module psc_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (restart_i)
            cnt_d = {{(CNT_W-1){1'b0}}, inc_i};
        else if (inc_i && (cnt_q != TOP))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/psc_upd_fsm.sv
module psc_upd_fsm
    import psc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic load_o,
    output logic ready_o,
    output logic nz_mask_o
);
    psc_state_e state_q;
    psc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rise_i) state_d = ST_SNAP;
            ST_SNAP:  state_d = ST_READY;
            ST_READY: if (rise_i) state_d = ST_SNAP;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o    = 1'b0;
        ready_o   = 1'b0;
        nz_mask_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SNAP:  begin
                load_o    = 1'b1;
                nz_mask_o = 1'b1;
            end
            ST_READY: ready_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/perf_snap_counter.sv
module perf_snap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             upd_req,
    output logic [CNT_W-1:0] snap_q,
    output logic             upd_ready,
    output logic             snap_nz
);
    logic             rise;
    logic             load;
    logic             nz_mask;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] hold_q;

    psc_rise_det u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (upd_req),
        .rise_o (rise)
    );

    psc_upd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .load_o    (load),
        .ready_o   (upd_ready),
        .nz_mask_o (nz_mask)
    );

    psc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (evt),
        .restart_i (load),
        .cnt_o     (run_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= run_cnt;
    end

    assign snap_q  = hold_q;
    assign snap_nz = (hold_q != '0) && !nz_mask;
endmodule

// File: rtl/perf_snap_counter_chk.sv
module perf_snap_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt,
    input logic             upd_req,
    input logic             load,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] snap_q,
    input logic             upd_ready,
    input logic             snap_nz
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == TOP && !load) |=> (run_cnt == TOP));

    a_r5_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_req) |=> (!upd_ready && !snap_nz));

    a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (snap_q == $past(run_cnt)));

    a_r9_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (run_cnt == {{(CNT_W-1){1'b0}}, $past(evt)}));

    a_r8_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ready && !upd_req) |=> upd_ready);

    a_r7_nz_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

bind perf_snap_counter perf_snap_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .upd_req   (upd_req),
    .load      (load),
    .run_cnt   (run_cnt),
    .snap_q    (snap_q),
    .upd_ready (upd_ready),
    .snap_nz   (snap_nz)
);

// File: tb/sim_perf_snap_counter.sv
module sim_perf_snap_counter;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int TOPV   = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt = 1'b0;
    logic         upd_req = 1'b0;
    logic [W-1:0] snap_q;
    logic         upd_ready;
    logic         snap_nz;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // behavioural reference: phase 0 idle, 1 update cycle, 2 ready
    int m_cnt = 0, m_hold = 0, m_phase = 0;
    bit m_prev = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    perf_snap_counter #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .evt(evt), .upd_req(upd_req),
        .snap_q(snap_q), .upd_ready(upd_ready), .snap_nz(snap_nz)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_hold = 0; m_phase = 0; m_prev = 1'b0;
        end else begin
            bit rise_now;
            rise_now = upd_req && !m_prev;
            m_prev   = upd_req;
            if (m_phase == 1) begin
                m_hold  = m_cnt;
                m_cnt   = evt ? 1 : 0;
                m_phase = 2;
            end else begin
                if (evt && m_cnt < TOPV) m_cnt = m_cnt + 1;
                if (rise_now) m_phase = 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 snap_q vs model", snap_q, m_hold);
            check("R8 upd_ready vs model", upd_ready, (m_phase == 2) ? 1 : 0);
            check("R7 snap_nz vs model", snap_nz, (m_phase != 1 && m_hold != 0) ? 1 : 0);
        end
    end

    task automatic cyc(input bit e, input bit r);
        evt = e;
        upd_req = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_update();
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int lows;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 snap_q in reset", snap_q, 0);
        check("R1 upd_ready in reset", upd_ready, 0);
        check("R1 snap_nz in reset", snap_nz, 0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        check("R1 upd_ready before first update", upd_ready, 0);

        // R2, R5, R6, R7, R8: five events then an update
        repeat (5) cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        check("R5 upd_ready low in update cycle", upd_ready, 0);
        check("R7 snap_nz forced low", snap_nz, 0);
        cyc(1'b0, 1'b0);
        check("R2 five events counted", snap_q, 5);
        check("R8 upd_ready high after update", upd_ready, 1);
        check("R7 snap_nz high for non-zero", snap_nz, 1);
        repeat (3) cyc(1'b0, 1'b0);
        check("R8 upd_ready held", upd_ready, 1);

        // R6: event on the rising-request edge is in the snapshot
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b0);
        check("R6 event at request edge counted", snap_q, 1);

        // R9: event on the load edge goes to the fresh counter
        cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        check("R9 load-edge snapshot", snap_q, 0);
        do_update();
        check("R9 load-edge event kept", snap_q, 1);

        // R4: held request gives one update only
        lows = 0;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b1, 1'b1);
            if (!upd_ready) lows++;
        end
        check("R4 single update for held request", lows, 1);
        check("R4 snapshot after held request", snap_q, 1);
        cyc(1'b0, 1'b0);

        // R3: saturation
        repeat (300) cyc(1'b1, 1'b0);
        do_update();
        check("R3 saturated snapshot", snap_q, TOPV);

        // R10: two updates with no events clear the snapshot
        do_update();
        check("R10 second update zero", snap_q, 0);
        check("R10 snap_nz low on zero", snap_nz, 0);

        // R11: reset in mid operation
        repeat (3) cyc(1'b1, 1'b0);
        do_update();
        check("R11 snapshot before reset", snap_q, 3);
        repeat (4) cyc(1'b1, 1'b0);
        rst_n = 1'b0;
        cyc(1'b0, 1'b0);
        check("R11 snap_q cleared", snap_q, 0);
        check("R11 upd_ready cleared", upd_ready, 0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);
        do_update();
        check("R11 counter cleared", snap_q, 0);

        // random mix, judged by the model
        for (int i = 0; i < 4000; i++) begin
            bit e, r;
            e = ($urandom_range(0, 3) != 0);
            r = ($urandom_range(0, 9) < 3) ? ~upd_req : upd_req;
            cyc(e, r);
        end
        repeat (300) cyc(1'b1, 1'b0);
        do_update();
        check("R3 saturated after random run", snap_q, TOPV);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule